// File: doc/BRIEF.md
# Paged Serial-ROM Port Emulator

This block sits on a host's shared 8-bit data bus. To the host it looks like a byte-serial graphics-ROM device. The host reaches it through a small group of memory-mapped ports. One port loads an internal 16-bit pointer, one byte per write. One port moves data bytes at the pointer, which advances by one after every transfer. One port reads the pointer back. One port writes a slot-control byte. The 64 KB serial space is cut into eight 8 KB slots. The control byte can re-point any slot at run time to one of four backings: computed ROM contents, read/write RAM, a separate nonvolatile store, or a small block of device registers. Because every slot is remappable, ROM pages placed from 0x6000 to 0xFFFF can sit beside cartridge CPU ROM at those same addresses.

Several port bases are decoded, eight by default. Each base is an independent context with its own pointer, byte-phase flip-flop, read buffer and slot map. All bases share one backing store. Each context runs a three-state machine. In CX_IDLE the next pointer-port access is the high byte. CX_HALF is entered from CX_IDLE by a pointer write (high byte captured) or a pointer read (high byte returned); in CX_HALF the next pointer-port access is the low byte. CX_FILL is the one cycle in which the read buffer is refilled from the byte at the pointer.

The transitions are as follows. CX_IDLE goes to CX_HALF on a pointer access and to CX_FILL on a data access. CX_HALF goes to CX_FILL on a pointer write (the pointer is loaded) or on a data access (the phase is reset), and goes back to CX_IDLE on a pointer read. CX_FILL always goes to CX_IDLE.

Top module: `pr_emu`

## Requirements
- R1: The block drives the bus (`bus_oe`=1) only in a read cycle whose address has bits [15:6] = 0x98>>... pattern `1001100000` (0x9800 range), bit 0 = 0, bits [2:1] = 00 (data) or 01 (pointer), and a base field bits [5:3] below the base count. Every other cycle, including reads of the control port (bits [2:1] = 10), reads in the 0x9C00 range and all writes, leaves `bus_oe`=0 and `bus_rdata`=0. Writes use the 0x9C00 range (bits [15:6] = `1001110000`) with the same field layout.
- R2: The pointer is loaded by two writes to the pointer port (sel 01), high byte first. The pointer takes the new value only after the low byte.
- R3: After a pointer load, the next data read returns the byte at the loaded address. Each data read or data write advances the pointer by one, and the pointer wraps from 0xFFFF to 0x0000.
- R4: Two reads of the pointer port return the current pointer, high byte then low byte. Any data access resets the byte phase, so the next pointer-port access is a high byte again.
- R5: A ROM-backed slot returns addr[7:0] XOR addr[15:8] XOR (page<<5). Writes to a ROM-backed slot change no stored byte but still advance the pointer.
- R6: The control byte (sel 10) holds the slot number in [7:5], the backing kind in [4:3] (0 ROM, 1 RAM, 2 nonvolatile, 3 device) and the page in [2:0]. After reset, every slot of every base is ROM page 0. A remap takes effect at the next refill and leaves a byte already buffered unchanged.
- R7: RAM holds 2048 bytes by default. Each page is a 256-byte window at index page*256 + addr[7:0], so addresses in a slot that agree in their low 8 bits alias.
- R8: Nonvolatile storage is a separate 512-byte array. Each page is a 64-byte window at index page*64 + addr[5:0]. Its contents are independent of RAM.
- R9: A device-backed slot exposes four 8-bit registers selected by addr[1:0], which read 0 after reset and hold the last byte written.
- R10: Each base (field bits [5:3]) has its own pointer, byte phase, buffer and slot map. Accesses to one base leave every other base unchanged.
- R11: When one base refills from a storage byte in the same cycle that another base writes that byte, the refill captures the value held before the write.
- R12: A base must see no access in its refill cycle, the cycle after a data access or pointer load. Other bases may be accessed in that cycle, and only one base refills at a time.
- R13: After reset every pointer is 0x0000, the phase expects a high byte, and the buffer holds the ROM byte at address 0 (0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Host address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, zero when not driving |
| bus_oe | output | 1 | High while the block drives the shared bus |

## Verification
Two functions can land in the same cycle. One base refills its read buffer from shared storage while the host, on a different base, writes that same RAM byte. The bench provokes this by sending the low pointer byte to one base and, in the very next cycle with no idle between, a data write to another base whose pointer sits on the same RAM byte. Success means the refilling base first returns the old byte, a later reload returns the new byte, and the writing base's pointer has advanced normally. A page flip against an already buffered byte is judged the same way: the bench checks that the buffered byte keeps its old page and that the byte after it follows the new map.

// File: rtl/pr_pkg.sv
package pr_pkg;

    localparam int PAGE_W   = 3;
    localparam int SLOT_W   = 3;
    localparam int PTR_W    = 16;
    localparam int SLOT_OFF = PTR_W - SLOT_W;
    localparam int NSLOT    = 1 << SLOT_W;

    typedef enum logic [1:0] {
        BK_ROM = 2'd0,
        BK_RAM = 2'd1,
        BK_NV  = 2'd2,
        BK_DEV = 2'd3
    } backing_e;

    typedef struct packed {
        backing_e              kind;
        logic [PAGE_W-1:0]     page;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        CX_IDLE = 2'd0,
        CX_HALF = 2'd1,
        CX_FILL = 2'd2
    } cx_state_e;

    function automatic logic [7:0] rom_byte(input logic [PTR_W-1:0] a,
                                            input logic [PAGE_W-1:0] pg);
        return a[7:0] ^ a[15:8] ^ {pg, 5'b00000};
    endfunction

endpackage

// File: rtl/pr_store.sv
module pr_store
    import pr_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int NV_AW  = 9,
    parameter int DEV_AW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_cfg_t            rd_cfg,
    input  logic [SLOT_OFF-1:0]  rd_off,
    input  logic [7:0]           rd_hi,
    output logic [7:0]           rd_data,
    input  logic                 wr_en,
    input  slot_cfg_t            wr_cfg,
    input  logic [SLOT_OFF-1:0]  wr_off,
    input  logic [7:0]           wr_data
);

    localparam int RAM_WIN   = RAM_AW - PAGE_W;
    localparam int NV_WIN    = NV_AW - PAGE_W;
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int NV_DEPTH  = 1 << NV_AW;
    localparam int DEV_NUM   = 1 << DEV_AW;

    logic [7:0] ram_q [RAM_DEPTH];
    logic [7:0] nv_q  [NV_DEPTH];
    logic [7:0] dev_q [DEV_NUM];

    logic [RAM_AW-1:0] ram_rd_idx, ram_wr_idx;
    logic [NV_AW-1:0]  nv_rd_idx,  nv_wr_idx;
    logic [DEV_AW-1:0] dev_rd_idx, dev_wr_idx;

    always_comb begin
        ram_rd_idx = {rd_cfg.page, rd_off[RAM_WIN-1:0]};
        ram_wr_idx = {wr_cfg.page, wr_off[RAM_WIN-1:0]};
        nv_rd_idx  = {rd_cfg.page, rd_off[NV_WIN-1:0]};
        nv_wr_idx  = {wr_cfg.page, wr_off[NV_WIN-1:0]};
        dev_rd_idx = rd_off[DEV_AW-1:0];
        dev_wr_idx = wr_off[DEV_AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_cfg.kind == BK_RAM)
            ram_q[ram_wr_idx] <= wr_data;
        if (wr_en && wr_cfg.kind == BK_NV)
            nv_q[nv_wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEV_NUM; i++) dev_q[i] <= 8'h00;
        end else if (wr_en && wr_cfg.kind == BK_DEV) begin
            dev_q[dev_wr_idx] <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_cfg.kind)
            BK_ROM:  rd_data = rom_byte({rd_hi[7:5], rd_off}, rd_cfg.page);
            BK_RAM:  rd_data = ram_q[ram_rd_idx];
            BK_NV:   rd_data = nv_q[nv_rd_idx];
            BK_DEV:  rd_data = dev_q[dev_rd_idx];
            default: rd_data = 8'h00;
        endcase
    end

    logic unused_hi;
    assign unused_hi = ^rd_hi[4:0];

    // R9
    dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_cfg.kind == BK_DEV) |=> $stable(dev_q[0]) && $stable(dev_q[DEV_NUM-1]))
        else $error("device register changed without a device write");

endmodule

// File: rtl/pr_ctx.sv
module pr_ctx
    import pr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic              d_wr,
    input  logic              d_rd,
    input  logic              c_wr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        fill_data,
    output logic [PTR_W-1:0]  ptr,
    output slot_cfg_t         cur_cfg,
    output logic              filling,
    output logic [7:0]        rd_byte
);

    cx_state_e        st_q, st_nx;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       hi_q;
    logic [7:0]       buf_q;
    slot_cfg_t        map_q [NSLOT];
    logic             any_acc;

    assign any_acc = a_wr | a_rd | d_wr | d_rd | c_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CX_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CX_IDLE: begin
                if (a_wr || a_rd)      st_nx = CX_HALF;
                else if (d_rd || d_wr) st_nx = CX_FILL;
            end
            CX_HALF: begin
                if (a_wr)              st_nx = CX_FILL;
                else if (a_rd)         st_nx = CX_IDLE;
                else if (d_rd || d_wr) st_nx = CX_FILL;
            end
            CX_FILL: st_nx = CX_IDLE;
            default: st_nx = CX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            hi_q  <= 8'h00;
            buf_q <= rom_byte('0, '0);
            for (int s = 0; s < NSLOT; s++) map_q[s] <= '{kind: BK_ROM, page: '0};
        end else begin
            if (st_q == CX_IDLE && a_wr) hi_q <= wdata;
            if (st_q == CX_HALF && a_wr)
                ptr_q <= {hi_q, wdata};
            else if (st_q != CX_FILL && (d_rd || d_wr))
                ptr_q <= ptr_q + 16'd1;
            if (st_q == CX_FILL) buf_q <= fill_data;
            if (c_wr) map_q[wdata[7:5]] <= '{kind: backing_e'(wdata[4:3]), page: wdata[2:0]};
        end
    end

    always_comb begin
        ptr     = ptr_q;
        cur_cfg = map_q[ptr_q[PTR_W-1:SLOT_OFF]];
        filling = (st_q == CX_FILL);
        if (a_rd) rd_byte = (st_q == CX_HALF) ? ptr_q[7:0] : ptr_q[15:8];
        else      rd_byte = buf_q;
    end

    // R12
    fill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CX_FILL) |-> !any_acc)
        else $error("access to a base during its refill cycle");

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CX_HALF && a_wr) |=> ptr_q == {$past(hi_q), $past(wdata)})
        else $error("pointer not loaded from high and low bytes");

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CX_FILL && !a_wr && (d_rd || d_wr)) |=> ptr_q == $past(ptr_q) + 16'd1)
        else $error("pointer did not advance after data access");

endmodule

// File: rtl/pr_emu.sv
module pr_emu
    import pr_pkg::*;
#(
    parameter int N_BASE = 8,
    parameter int RAM_AW = 11,
    parameter int NV_AW  = 9,
    parameter int DEV_AW = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_oe
);

    localparam int         BASE_W  = $clog2(N_BASE);
    localparam logic [9:0] RD_PAGE = 10'b1001100000;
    localparam logic [9:0] WR_PAGE = 10'b1001110000;

    logic [2:0]        base_fld;
    logic [1:0]        sel;
    logic              base_ok, rd_hit, wr_hit;
    logic [BASE_W-1:0] bidx;

    always_comb begin
        base_fld = bus_addr[5:3];
        sel      = bus_addr[2:1];
        base_ok  = ({1'b0, base_fld} < 4'(N_BASE)) && !bus_addr[0];
        rd_hit   = bus_rd && (bus_addr[15:6] == RD_PAGE) && base_ok;
        wr_hit   = bus_wr && (bus_addr[15:6] == WR_PAGE) && base_ok;
        bidx     = base_fld[BASE_W-1:0];
    end

    logic [PTR_W-1:0] ptr_v  [N_BASE];
    slot_cfg_t        cfg_v  [N_BASE];
    logic [7:0]       rb_v   [N_BASE];
    logic [N_BASE-1:0] fill_v, dwr_v;
    logic [7:0]       fill_data;

    for (genvar g = 0; g < N_BASE; g++) begin : g_ctx
        logic hit;
        assign hit = (bidx == BASE_W'(g));
        pr_ctx u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .a_wr      (wr_hit && hit && sel == 2'b01),
            .a_rd      (rd_hit && hit && sel == 2'b01),
            .d_wr      (dwr_v[g]),
            .d_rd      (rd_hit && hit && sel == 2'b00),
            .c_wr      (wr_hit && hit && sel == 2'b10),
            .wdata     (bus_wdata),
            .fill_data (fill_data),
            .ptr       (ptr_v[g]),
            .cur_cfg   (cfg_v[g]),
            .filling   (fill_v[g]),
            .rd_byte   (rb_v[g])
        );
        assign dwr_v[g] = wr_hit && hit && sel == 2'b00;
    end

    logic [PTR_W-1:0] fill_ptr;
    slot_cfg_t        fill_cfg;

    always_comb begin
        fill_ptr = '0;
        fill_cfg = '{kind: BK_ROM, page: '0};
        for (int g = 0; g < N_BASE; g++) begin
            if (fill_v[g]) begin
                fill_ptr = ptr_v[g];
                fill_cfg = cfg_v[g];
            end
        end
    end

    pr_store #(
        .RAM_AW (RAM_AW),
        .NV_AW  (NV_AW),
        .DEV_AW (DEV_AW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_cfg  (fill_cfg),
        .rd_off  (fill_ptr[SLOT_OFF-1:0]),
        .rd_hi   (fill_ptr[15:8]),
        .rd_data (fill_data),
        .wr_en   (|dwr_v),
        .wr_cfg  (cfg_v[bidx]),
        .wr_off  (ptr_v[bidx][SLOT_OFF-1:0]),
        .wr_data (bus_wdata)
    );

    always_comb begin
        bus_oe    = rd_hit && !sel[1];
        bus_rdata = bus_oe ? rb_v[bidx] : 8'h00;
    end

    // R12
    one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_v))
        else $error("more than one base refilling");

    // R1
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_wr) |-> !bus_oe && bus_rdata == 8'h00)
        else $error("bus driven outside a read cycle");

endmodule

// File: tb/sim_pr_emu.sv
`timescale 1ns/1ps
module sim_pr_emu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_oe;

    always #2 clk = ~clk;

    pr_emu u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe)
    );

    typedef struct { logic oe; logic [7:0] d; string tag; } exp_t;
    exp_t exp_q[$];
    logic mon_go = 1'b0;
    int   n_run = 0;
    int   n_bad = 0;

    function automatic logic [7:0] ref_rom(input logic [15:0] a, input logic [2:0] pg);
        return (a[15:8] ^ a[7:0]) ^ (8'(pg) << 5);
    endfunction

    function automatic logic [15:0] rport(input int b, input int s);
        return 16'h9800 | 16'(b << 3) | 16'(s << 1);
    endfunction

    function automatic logic [15:0] wport(input int b, input int s);
        return 16'h9C00 | 16'(b << 3) | 16'(s << 1);
    endfunction

    // monitor: pops one expected item per flagged cycle
    always @(negedge clk) begin
        #1;
        if (mon_go) begin
            exp_t e;
            n_run++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got oe=%0b data=%02h, expected an item", bus_oe, bus_rdata);
            end else begin
                e = exp_q.pop_front();
                if (bus_oe !== e.oe || bus_rdata !== e.d) begin
                    n_bad++;
                    $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                             e.tag, bus_oe, bus_rdata, e.oe, e.d);
                end
            end
        end
    end

    task automatic cyc(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d,
                       input logic chk, input logic eoe, input logic [7:0] ed, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d; mon_go = chk;
        if (chk) exp_q.push_back('{oe: eoe, d: ed, tag: tag});
    endtask

    task automatic idle();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; mon_go = 1'b0;
    endtask

    task automatic set_ptr(input int b, input logic [15:0] a);
        cyc(wport(b, 1), 0, 1, a[15:8], 0, 0, 0, ""); idle();
        cyc(wport(b, 1), 0, 1, a[7:0],  0, 0, 0, ""); idle();
    endtask

    task automatic rd_data(input int b, input logic [7:0] e, input string tag);
        cyc(rport(b, 0), 1, 0, 0, 1, 1, e, tag); idle();
    endtask

    task automatic wr_data(input int b, input logic [7:0] d);
        cyc(wport(b, 0), 0, 1, d, 1, 0, 8'h00, "R1 write cycle quiet"); idle();
    endtask

    task automatic rd_ptr(input int b, input logic [15:0] e, input string tag);
        cyc(rport(b, 1), 1, 0, 0, 1, 1, e[15:8], tag); idle();
        cyc(rport(b, 1), 1, 0, 0, 1, 1, e[7:0],  tag); idle();
    endtask

    task automatic ctl(input int b, input int slot, input int kind, input int pg);
        cyc(wport(b, 2), 0, 1, 8'((slot << 5) | (kind << 3) | pg), 0, 0, 0, ""); idle();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R13 reset state
        rd_ptr(0, 16'h0000, "R13 pointer after reset");
        rd_data(0, 8'h00, "R13 buffer after reset");

        // R2 R3 R5 load and stream ROM
        set_ptr(0, 16'h6123);
        rd_data(0, ref_rom(16'h6123, 0), "R3 first byte after load");
        rd_data(0, ref_rom(16'h6124, 0), "R5 rom byte");
        rd_data(0, ref_rom(16'h6125, 0), "R3 increment");
        rd_ptr(0, 16'h6126, "R4 readback");

        // R4 phase reset by data access
        set_ptr(0, 16'h7000);
        cyc(rport(0, 1), 1, 0, 0, 1, 1, 8'h70, "R4 high byte"); idle();
        rd_data(0, ref_rom(16'h7000, 0), "R4 data between");
        rd_ptr(0, 16'h7001, "R4 phase reset");

        // R5 ROM writes ignored
        set_ptr(0, 16'h8000);
        wr_data(0, 8'h55);
        rd_ptr(0, 16'h8001, "R5 pointer advanced by ROM write");
        set_ptr(0, 16'h8000);
        rd_data(0, ref_rom(16'h8000, 0), "R5 ROM unchanged");

        // R6 page flip
        ctl(0, 4, 0, 5);
        set_ptr(0, 16'h8010);
        rd_data(0, ref_rom(16'h8010, 5), "R6 page 5");
        set_ptr(0, 16'h8020);
        ctl(0, 4, 0, 2);
        rd_data(0, ref_rom(16'h8020, 5), "R6 buffered byte keeps page");
        rd_data(0, ref_rom(16'h8021, 2), "R6 next byte new page");

        // R7 RAM windows
        ctl(0, 3, 1, 1);
        set_ptr(0, 16'h6010);
        wr_data(0, 8'hA1);
        wr_data(0, 8'hA2);
        set_ptr(0, 16'h7010);
        rd_data(0, 8'hA1, "R7 alias low 8 bits");
        rd_data(0, 8'hA2, "R7 second byte");
        ctl(0, 3, 1, 2);
        set_ptr(0, 16'h6010);
        wr_data(0, 8'hB7);
        ctl(0, 3, 1, 1);
        set_ptr(0, 16'h6010);
        rd_data(0, 8'hA1, "R7 page 1 window");
        ctl(0, 3, 1, 2);
        set_ptr(0, 16'h6010);
        rd_data(0, 8'hB7, "R7 page 2 window");
        ctl(0, 3, 1, 1);

        // R8 nonvolatile separate from RAM
        ctl(0, 5, 1, 0);
        set_ptr(0, 16'hA005);
        wr_data(0, 8'h11);
        ctl(0, 5, 2, 0);
        set_ptr(0, 16'hA005);
        wr_data(0, 8'hC3);
        ctl(0, 5, 1, 0);
        set_ptr(0, 16'hA005);
        rd_data(0, 8'h11, "R8 RAM untouched by NV write");
        ctl(0, 5, 2, 0);
        set_ptr(0, 16'hA045);
        rd_data(0, 8'hC3, "R8 NV 64-byte window");

        // R9 device registers
        ctl(0, 6, 3, 0);
        set_ptr(0, 16'hC000);
        rd_data(0, 8'h00, "R9 reset value");
        set_ptr(0, 16'hC001);
        wr_data(0, 8'h3C);
        set_ptr(0, 16'hC005);
        rd_data(0, 8'h3C, "R9 register 1");
        set_ptr(0, 16'hC002);
        rd_data(0, 8'h00, "R9 register 2 untouched");

        // R10 independent bases
        set_ptr(0, 16'h9000);
        set_ptr(3, 16'h6010);
        rd_data(3, ref_rom(16'h6010, 0), "R10 base 3 map still ROM");
        set_ptr(3, 16'hE000);
        rd_ptr(0, 16'h9000, "R10 base 0 pointer kept");
        rd_ptr(3, 16'hE000, "R10 base 3 pointer");

        // R1 bus drive rules
        cyc(rport(0, 2), 1, 0, 0, 1, 0, 8'h00, "R1 control port read"); idle();
        cyc(16'h9C00,    1, 0, 0, 1, 0, 8'h00, "R1 read in write range"); idle();
        cyc(16'h9400,    1, 0, 0, 1, 0, 8'h00, "R1 foreign address"); idle();
        cyc(16'h9801,    1, 0, 0, 1, 0, 8'h00, "R1 odd address"); idle();
        rd_ptr(0, 16'h9000, "R1 stray reads left pointer");

        // R11 R12 refill of base 1 against write of base 0, same byte
        ctl(1, 3, 1, 1);
        set_ptr(0, 16'h6010);
        cyc(wport(1, 1), 0, 1, 8'h60, 0, 0, 0, ""); idle();
        cyc(wport(1, 1), 0, 1, 8'h10, 0, 0, 0, "");
        cyc(wport(0, 0), 0, 1, 8'h5A, 0, 0, 0, "");
        idle();
        rd_data(1, 8'hA1, "R11 refill saw pre-write byte");
        rd_ptr(0, 16'h6011, "R12 other base served during refill");
        set_ptr(1, 16'h6010);
        rd_data(1, 8'h5A, "R11 write landed");

        // R3 wrap
        set_ptr(0, 16'hFFFF);
        rd_data(0, ref_rom(16'hFFFF, 0), "R3 last address");
        rd_data(0, ref_rom(16'h0000, 0), "R3 wrap to zero");
        rd_ptr(0, 16'h0001, "R3 pointer after wrap");

        repeat (4) idle();
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d leftover items, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule